// File: doc/BRIEF.md
# Receive Flow-Control Hysteresis for RTS

This block drives an active-low request-to-send line from the fill level of a receive FIFO. It builds two thresholds around a programmed trigger level: an upper one at the trigger plus a hysteresis amount, and a lower one at the trigger minus that amount. When the character count climbs to the upper threshold, the line goes high and asks the far end to pause. When the count drains to the lower threshold or below, the line goes low again. Between the two thresholds the line keeps the level it already has.

A 4-bit code picks the hysteresis amount. The code does not map to the amounts in rising order. The code only counts when both extended-table mode bits are set; otherwise the band is zero. With auto flow control off, the line simply copies a software-written bit. The block is a small datapath that holds the decoded hysteresis and forms the threshold compares, plus a control stage that owns the output register.

Top module: `rts_hysteresis`

## Requirements
- R1: With mode bits `2'b11`, select codes 0 to 7 give a band of 0, 4, 6, 8, 8, 16, 24 and 32 characters.
- R2: With mode bits `2'b11`, select codes 8, 9, 10 and 11 give a band of 40, 44, 48 and 52 characters.
- R3: With mode bits `2'b11`, select codes 12, 13, 14 and 15 give a band of 12, 20, 28 and 36 characters.
- R4: With auto flow on, `rtsN` is 1 one clock after the count is at or above trigger + band.
- R5: With auto flow on, `rtsN` is 0 one clock after the count is at or below trigger − band and below the upper threshold. With a zero band, the line therefore drops at trigger − 1.
- R6: With auto flow on and the count strictly between the two thresholds, `rtsN` keeps its previous value.
- R7: When `tableMode` is anything other than `2'b11`, the select code is ignored and the band is zero.
- R8: The lower threshold saturates at 0. The upper threshold saturates at `DEPTH`.
- R9: With auto flow off, `rtsN` equals `swRtsN` one clock later, whatever the FIFO count is.
- R10: During reset `rtsN` is 1 and the decoded band is 0. A new select code or mode reaches the compare two clocks after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoCount | input | CNT_W | Characters held in the receive FIFO |
| trigLevel | input | CNT_W | Receive trigger level, at most DEPTH |
| hystSel | input | 4 | Hysteresis select code |
| tableMode | input | 2 | Extended-table mode bits; both set enables the select |
| autoEn | input | 1 | 1: automatic flow control, 0: software bit drives the line |
| swRtsN | input | 1 | Software-written line level |
| rtsN | output | 1 | Active-low request to send |

## Verification
A change on `fifoCount`, `autoEn` or `swRtsN` shows on `rtsN` after one rising edge, because only the output register lies on that path. A change on `hystSel` or `tableMode` first passes the decoded-band register, so its effect is due after two edges. The bench drives every input on a falling edge. After each single count step it samples one falling edge later, so exactly one rising edge has passed. After any configuration change it waits three edges before it starts sweeping.

// File: rtl/rts_hyst_pkg.sv
package rts_hyst_pkg;

  localparam int HYST_W = 6;

  typedef struct packed {
    logic crossHigh;  // count at or above upper threshold
    logic crossLow;   // count at or below lower threshold
  } rtsStrobe_t;

  // Non-monotonic select-code to band mapping.
  function automatic logic [HYST_W-1:0] hystFromCode(input logic [3:0] code);
    logic [HYST_W-1:0] v;
    case (code)
      4'd0:  v = 6'd0;
      4'd1:  v = 6'd4;
      4'd2:  v = 6'd6;
      4'd3:  v = 6'd8;
      4'd4:  v = 6'd8;
      4'd5:  v = 6'd16;
      4'd6:  v = 6'd24;
      4'd7:  v = 6'd32;
      4'd8:  v = 6'd40;
      4'd9:  v = 6'd44;
      4'd10: v = 6'd48;
      4'd11: v = 6'd52;
      4'd12: v = 6'd12;
      4'd13: v = 6'd20;
      4'd14: v = 6'd28;
      default: v = 6'd36;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/rts_hyst_datapath.sv
module rts_hyst_datapath
  import rts_hyst_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic [3:0]       hystSel,
  input  logic [1:0]       tableMode,
  output rtsStrobe_t       strobe
);

  localparam int SUM_W = CNT_W + 1;
  localparam logic [SUM_W-1:0] DEPTH_S = SUM_W'(DEPTH);

  logic [HYST_W-1:0] hystReg;
  logic [SUM_W-1:0]  upperRaw;
  logic [CNT_W-1:0]  upperThr;
  logic [CNT_W-1:0]  lowerThr;
  logic [CNT_W-1:0]  hystWide;
  logic              tableOn;

  assign tableOn = (tableMode == 2'b11);

  always_ff @(posedge clk) begin
    if (!rstN)        hystReg <= '0;
    else if (tableOn) hystReg <= hystFromCode(hystSel);
    else              hystReg <= '0;
  end

  assign hystWide = CNT_W'(hystReg);
  assign upperRaw = SUM_W'(trigLevel) + SUM_W'(hystReg);

  always_comb begin
    if (upperRaw > DEPTH_S) upperThr = CNT_W'(DEPTH);
    else                    upperThr = upperRaw[CNT_W-1:0];
    if (trigLevel > hystWide) lowerThr = trigLevel - hystWide;
    else                      lowerThr = '0;
  end

  assign strobe.crossHigh = (fifoCount >= upperThr);
  assign strobe.crossLow  = (fifoCount <= lowerThr);

  // The lower threshold never sits above the trigger.
  p_low_under_trig_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.crossLow |-> (fifoCount <= trigLevel));

  // A full FIFO always lies at or above the saturated upper threshold.
  p_full_is_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount >= CNT_W'(DEPTH)) |-> strobe.crossHigh);

  // Without the extended table, the band is zero: the high compare equals count >= trigger.
  p_mode_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    !tableOn |=> (trigLevel > CNT_W'(DEPTH)) || (strobe.crossHigh == (fifoCount >= trigLevel)));

endmodule

// File: rtl/rts_flow_ctrl.sv
module rts_flow_ctrl
  import rts_hyst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       autoEn,
  input  logic       swRtsN,
  input  rtsStrobe_t strobe,
  output logic       rtsN
);

  always_ff @(posedge clk) begin
    if (!rstN)                 rtsN <= 1'b1;
    else if (!autoEn)          rtsN <= swRtsN;
    else if (strobe.crossHigh) rtsN <= 1'b1;
    else if (strobe.crossLow)  rtsN <= 1'b0;
  end

  p_deassert_r4: assert property (@(posedge clk) disable iff (!rstN)
    (autoEn && strobe.crossHigh) |=> rtsN);

  p_assert_r5: assert property (@(posedge clk) disable iff (!rstN)
    (autoEn && strobe.crossLow && !strobe.crossHigh) |=> !rtsN);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (autoEn && !strobe.crossLow && !strobe.crossHigh) |=> $stable(rtsN));

  p_sw_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    !autoEn |=> (rtsN == $past(swRtsN)));

  p_reset_high_r10: assert property (@(posedge clk)
    !rstN |=> rtsN);

endmodule

// File: rtl/rts_hysteresis.sv
module rts_hysteresis
  import rts_hyst_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic [3:0]       hystSel,
  input  logic [1:0]       tableMode,
  input  logic             autoEn,
  input  logic             swRtsN,
  output logic             rtsN
);

  rtsStrobe_t strobe;

  rts_hyst_datapath #(.DEPTH(DEPTH)) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .fifoCount (fifoCount),
    .trigLevel (trigLevel),
    .hystSel   (hystSel),
    .tableMode (tableMode),
    .strobe    (strobe)
  );

  rts_flow_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .autoEn (autoEn),
    .swRtsN (swRtsN),
    .strobe (strobe),
    .rtsN   (rtsN)
  );

endmodule

// File: tb/sim_rts_hysteresis.sv
`timescale 1ns/1ps
module sim_rts_hysteresis;

  localparam int DEPTH = 128;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int NVEC  = 20;

  // Vector layout: {tableMode[1:0], hystSel[3:0], trigLevel[7:0], expected band[5:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {2'b11, 4'd0,  8'd64,  6'd0},
    {2'b11, 4'd1,  8'd64,  6'd4},
    {2'b11, 4'd2,  8'd64,  6'd6},
    {2'b11, 4'd3,  8'd64,  6'd8},
    {2'b11, 4'd4,  8'd64,  6'd8},
    {2'b11, 4'd5,  8'd64,  6'd16},
    {2'b11, 4'd6,  8'd64,  6'd24},
    {2'b11, 4'd7,  8'd64,  6'd32},
    {2'b11, 4'd8,  8'd64,  6'd40},
    {2'b11, 4'd9,  8'd64,  6'd44},
    {2'b11, 4'd10, 8'd64,  6'd48},
    {2'b11, 4'd11, 8'd64,  6'd52},
    {2'b11, 4'd12, 8'd64,  6'd12},
    {2'b11, 4'd13, 8'd64,  6'd20},
    {2'b11, 4'd14, 8'd64,  6'd28},
    {2'b11, 4'd15, 8'd64,  6'd36},
    {2'b11, 4'd11, 8'd100, 6'd52},
    {2'b11, 4'd11, 8'd20,  6'd52},
    {2'b01, 4'd7,  8'd64,  6'd0},
    {2'b10, 4'd9,  8'd30,  6'd0}
  };

  logic             clk = 1'b0;
  logic             rstN;
  logic [CNT_W-1:0] fifoCount;
  logic [CNT_W-1:0] trigLevel;
  logic [3:0]       hystSel;
  logic [1:0]       tableMode;
  logic             autoEn;
  logic             swRtsN;
  logic             rtsN;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  rts_hysteresis #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .fifoCount(fifoCount), .trigLevel(trigLevel),
    .hystSel(hystSel), .tableMode(tableMode), .autoEn(autoEn),
    .swRtsN(swRtsN), .rtsN(rtsN)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one count on a falling edge, return one rising edge later.
  task automatic setCount(input int c);
    @(negedge clk);
    fifoCount = CNT_W'(c);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; fifoCount = CNT_W'(63); trigLevel = CNT_W'(64);
    hystSel = 4'd15; tableMode = 2'b11; autoEn = 1'b1; swRtsN = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 reset level", int'(rtsN), 1);
    rstN = 1'b1;
    @(negedge clk);
    // First edge after reset uses the zero band: 63 <= 64 pulls the line low.
    check("R10 band zero after reset", int'(rtsN), 0);

    for (int v = 0; v < NVEC; v++) begin
      automatic logic [1:0] md  = VEC[v][19:18];
      automatic logic [3:0] cd  = VEC[v][17:14];
      automatic int         tr  = int'(VEC[v][13:6]);
      automatic int         h   = int'(VEC[v][5:0]);
      automatic string      grp = (v >= 18) ? "R7" : (v >= 16) ? "R8" :
                                  (cd < 8) ? "R1" : (cd < 12) ? "R2" : "R3";
      automatic int expUp = (tr + h > DEPTH) ? DEPTH : tr + h;
      automatic int expDn = (h == 0) ? tr - 1 : ((tr > h) ? tr - h : 0);
      automatic int upPt = -1;
      automatic int dnPt = -1;
      @(negedge clk);
      tableMode = md; hystSel = cd; trigLevel = CNT_W'(tr); fifoCount = '0;
      settle();
      for (int c = 0; c <= DEPTH; c++) begin
        setCount(c);
        if (rtsN && upPt < 0) upPt = c;
      end
      for (int c = DEPTH; c >= 0; c--) begin
        setCount(c);
        if (!rtsN && dnPt < 0) dnPt = c;
      end
      check($sformatf("R4 %s code %0d rise point", grp, cd), upPt, expUp);
      check($sformatf("R5 %s code %0d fall point", grp, cd), dnPt, expDn);
    end

    // Hold inside the band: code 1 gives 4, trigger 64 -> thresholds 68 / 60.
    @(negedge clk);
    tableMode = 2'b11; hystSel = 4'd1; trigLevel = CNT_W'(64); fifoCount = '0;
    settle();
    check("R5 start low", int'(rtsN), 0);
    setCount(70); check("R4 above upper", int'(rtsN), 1);
    setCount(66); check("R6 hold high in band", int'(rtsN), 1);
    setCount(60); check("R5 at lower", int'(rtsN), 0);
    setCount(66); check("R6 hold low in band", int'(rtsN), 0);

    // Software control ignores the count.
    @(negedge clk); autoEn = 1'b0; swRtsN = 1'b1;
    @(negedge clk); check("R9 follow sw high", int'(rtsN), 1);
    @(negedge clk); swRtsN = 1'b0;
    @(negedge clk); check("R9 follow sw low", int'(rtsN), 0);
    setCount(DEPTH); check("R9 full count ignored", int'(rtsN), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule